// File: doc/BRIEF.md
# Transmit Phase-Compensation Byte Serializer

This block sits on the transmit side of a transceiver, between core logic and a symbol encoder. Core logic hands it 16-bit words. Each word comes with two per-lane sideband bits: a control-enable flag and a force-disparity flag, one bit for each byte lane. The words cross from the core write clock into the transmit read clock through a small dual-clock FIFO that is always in the path. The two clocks must share one frequency. The FIFO only absorbs their phase offset and does no rate matching. A byte serializer on a clock running at exactly twice the read clock then sends each word as two bytes. The low byte (bits 7:0) goes first and the high byte (bits 15:8) second. Each byte leaves with the sideband bits of its own lane.

The write side is a valid/ready stream. A word moves on a write-clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when the FIFO is full. The source must then hold the word and its flags stable. Keeping `in_valid` high against a low `in_ready` is treated as a rate fault and is recorded. The output side has no back-pressure: a byte is presented in every byte slot, and `out_valid` marks the slots that carry data. One active-low asynchronous reset restarts both FIFO pointers, the serializer phase and the error flags. It must be applied whenever the clocking state is in doubt.

Top module: `txpc_serializer`

## Requirements
- R1: For every word read from the FIFO, the byte output carries bits 7:0 in one byte slot and bits 15:8 in the next byte slot. The high slot is always followed by a low slot.
- R2: Lane 0 of the control-enable and force-disparity inputs appears on `out_ctrl` and `out_fdisp` with the low byte. Lane 1 appears with the high byte.
- R3: Every accepted word leaves in acceptance order, exactly once. There is no path that skips the FIFO.
- R4: `in_ready` is low exactly when the FIFO (8 entries by default) is full. No word is written on an edge where `in_ready` is low.
- R5: `tx_overflow` sets when `in_valid` is high while `in_ready` is low. It stays set until reset.
- R6: Once reading has begun, a read-clock cycle that finds the FIFO empty sets `tx_underflow`, which stays set until reset. Both byte slots of that cycle have `out_valid` low.
- R7: Whenever `out_valid` is low, `out_byte`, `out_ctrl` and `out_fdisp` are all zero. This includes the whole time from reset until the first word is read.
- R8: Reading begins only after the read side has seen at least 2 words written. A single word written after reset is never emitted until a second word arrives. After that, one read is attempted on every read-clock cycle.
- R9: Reset clears both error flags, the output and both FIFO pointers, leaving `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Core write clock |
| rd_clk | input | 1 | Transmit word clock, same frequency as wr_clk |
| byte_clk | input | 1 | Byte clock, twice rd_clk and rising with it |
| rst_n | input | 1 | Active-low asynchronous digital reset |
| in_valid | input | 1 | Word offered on the write side |
| in_ready | output | 1 | FIFO can take a word |
| in_data | input | 16 | Word, low byte in bits 7:0 |
| in_ctrl | input | 2 | Control-enable flag per byte lane |
| in_fdisp | input | 2 | Force-disparity flag per byte lane |
| out_byte | output | 8 | Serialized byte |
| out_ctrl | output | 1 | Control-enable flag of the current byte |
| out_fdisp | output | 1 | Force-disparity flag of the current byte |
| out_valid | output | 1 | Current byte slot carries data |
| tx_overflow | output | 1 | Sticky write-while-full flag |
| tx_underflow | output | 1 | Sticky read-while-empty flag |

## Verification
A corrupted pointer or synchronizer shows up at the output within a few read-clock cycles. It appears as a dropped, repeated or reordered byte pair, which the in-order scoreboard catches on the next valid slot. A wrong serializer phase swaps the two halves of a word, or splits one word's lanes across two words. Because every byte is compared with its lane flags, the first valid byte pair after the fault exposes it. A bad start threshold or bad full logic shows up either as output appearing after a single word, or as `in_ready` falling at the wrong fill level. Each is checked within tens of cycles of the stimulus.

// File: rtl/txpc_pkg.sv
package txpc_pkg;
  localparam int SYM_W  = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = SYM_W * LANES;

  typedef struct packed {
    logic [LANES-1:0]  fdisp;
    logic [LANES-1:0]  ctrl;
    logic [WORD_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/txpc_sync.sv
module txpc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txpc_fifo.sv
module txpc_fifo #(
  parameter int W         = 20,
  parameter int DEPTH     = 8,
  parameter int START_LVL = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_data,
  output logic          ovf,
  output logic [W-1:0]  rd_data,
  output logic          rd_vld,
  output logic          rd_tgl,
  output logic          unf,
  output logic [$clog2(DEPTH):0] wr_gray_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] rd_gray_w, wr_gray_r;
  logic          full;

  // write domain
  txpc_sync #(.W(PW), .STAGES(2)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_w));

  assign full     = (wr_gray == {~rd_gray_w[PW-1:PW-2], rd_gray_w[PW-3:0]});
  assign wr_ready = !full;

  always_ff @(posedge wr_clk) begin
    if (wr_valid && !full) mem[wr_bin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      ovf     <= 1'b0;
    end else begin
      if (wr_valid && !full) begin
        wr_bin  <= wr_bin + PW'(1);
        wr_gray <= b2g(wr_bin + PW'(1));
      end
      if (wr_valid && full) ovf <= 1'b1;
    end
  end

  // read domain
  txpc_sync #(.W(PW), .STAGES(2)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_r));

  logic [PW-1:0] level;
  logic          started, go, empty;

  assign level = g2b(wr_gray_r) - rd_bin;
  assign empty = (level == '0);
  assign go    = started || (level >= PW'(START_LVL));

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      started <= 1'b0;
      rd_data <= '0;
      rd_vld  <= 1'b0;
      rd_tgl  <= 1'b0;
      unf     <= 1'b0;
    end else begin
      rd_tgl <= ~rd_tgl;
      if (go) begin
        started <= 1'b1;
        if (!empty) begin
          rd_data <= mem[rd_bin[AW-1:0]];
          rd_vld  <= 1'b1;
          rd_bin  <= rd_bin + PW'(1);
          rd_gray <= b2g(rd_bin + PW'(1));
        end else begin
          rd_data <= '0;
          rd_vld  <= 1'b0;
          unf     <= 1'b1;
        end
      end else begin
        rd_data <= '0;
        rd_vld  <= 1'b0;
      end
    end
  end

  assign wr_gray_o = wr_gray;
endmodule

// File: rtl/txpc_byte_ser.sv
module txpc_byte_ser
  import txpc_pkg::*;
(
  input  logic             byte_clk,
  input  logic             rst_n,
  input  tx_word_t         word_i,
  input  logic             word_vld,
  input  logic             word_tgl,
  output logic [SYM_W-1:0] out_byte,
  output logic             out_ctrl,
  output logic             out_fdisp,
  output logic             out_valid,
  output logic             slot_hi
);
  logic seen_tgl, new_word, lane;

  // a changed toggle marks the first byte slot after a read
  assign new_word = (word_tgl != seen_tgl);
  assign lane     = !new_word;

  always_ff @(posedge byte_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_tgl  <= 1'b0;
      slot_hi   <= 1'b0;
      out_byte  <= '0;
      out_ctrl  <= 1'b0;
      out_fdisp <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      seen_tgl <= word_tgl;
      slot_hi  <= lane;
      if (word_vld) begin
        out_byte  <= lane ? word_i.data[2*SYM_W-1:SYM_W] : word_i.data[SYM_W-1:0];
        out_ctrl  <= word_i.ctrl[lane];
        out_fdisp <= word_i.fdisp[lane];
        out_valid <= 1'b1;
      end else begin
        out_byte  <= '0;
        out_ctrl  <= 1'b0;
        out_fdisp <= 1'b0;
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txpc_serializer.sv
module txpc_serializer
  import txpc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int START_LVL = 2
) (
  input  logic                 wr_clk,
  input  logic                 rd_clk,
  input  logic                 byte_clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_data,
  input  logic [LANES-1:0]     in_ctrl,
  input  logic [LANES-1:0]     in_fdisp,
  output logic [SYM_W-1:0]     out_byte,
  output logic                 out_ctrl,
  output logic                 out_fdisp,
  output logic                 out_valid,
  output logic                 tx_overflow,
  output logic                 tx_underflow
);
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam int ENT_W = $bits(tx_word_t);

  tx_word_t         wr_word, rd_word;
  logic [ENT_W-1:0] rd_raw;
  logic             rd_vld, rd_tgl, slot_hi;
  logic [PTR_W-1:0] wr_ptr_g;

  assign wr_word = '{fdisp: in_fdisp, ctrl: in_ctrl, data: in_data};
  assign rd_word = tx_word_t'(rd_raw);

  txpc_fifo #(.W(ENT_W), .DEPTH(DEPTH), .START_LVL(START_LVL)) u_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(wr_word),
    .ovf(tx_overflow), .rd_data(rd_raw), .rd_vld(rd_vld),
    .rd_tgl(rd_tgl), .unf(tx_underflow), .wr_gray_o(wr_ptr_g));

  txpc_byte_ser u_ser (
    .byte_clk(byte_clk), .rst_n(rst_n), .word_i(rd_word),
    .word_vld(rd_vld), .word_tgl(rd_tgl), .out_byte(out_byte),
    .out_ctrl(out_ctrl), .out_fdisp(out_fdisp), .out_valid(out_valid),
    .slot_hi(slot_hi));
endmodule

// File: rtl/txpc_checker.sv
module txpc_checker #(
  parameter int PW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          byte_clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [PW-1:0] wr_ptr_g,
  input logic [7:0]    out_byte,
  input logic          out_ctrl,
  input logic          out_fdisp,
  input logic          out_valid,
  input logic          slot_hi,
  input logic          tx_overflow,
  input logic          tx_underflow
);
  a_r4_no_write_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !in_ready |=> $stable(wr_ptr_g));

  a_r5_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);

  a_r5_ovf_cause: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(tx_overflow) |-> $past(in_valid && !in_ready));

  a_r6_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rst_n)
    tx_underflow |=> tx_underflow);

  a_r7_idle_zero: assert property (@(posedge byte_clk) disable iff (!rst_n)
    !out_valid |-> (out_byte == 8'h00 && !out_ctrl && !out_fdisp));

  a_r1_slot_alt: assert property (@(posedge byte_clk) disable iff (!rst_n)
    (out_valid && slot_hi) |=> !slot_hi);

  a_r8_pair_valid: assert property (@(posedge byte_clk) disable iff (!rst_n)
    (out_valid && slot_hi) |-> $past(out_valid && !slot_hi));
endmodule

bind txpc_serializer txpc_checker #(.PW(PTR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .byte_clk(byte_clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready), .wr_ptr_g(wr_ptr_g),
  .out_byte(out_byte), .out_ctrl(out_ctrl), .out_fdisp(out_fdisp),
  .out_valid(out_valid), .slot_hi(slot_hi),
  .tx_overflow(tx_overflow), .tx_underflow(tx_underflow));

// File: tb/sim_txpc_serializer.sv
`timescale 1ns/1ps
module sim_txpc_serializer;
  logic wr_clk = 1'b0, rd_clk = 1'b0, byte_clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0] in_ctrl = '0, in_fdisp = '0;
  logic in_ready, out_ctrl, out_fdisp, out_valid, tx_overflow, tx_underflow;
  logic [7:0] out_byte;

  int checks = 0, errors = 0, seen_valid = 0, stalls = 0;
  bit mon_en = 1'b0, done = 1'b0;
  realtime wr_half = 5.0;
  logic [9:0] expq [$];

  txpc_serializer u0 (.*);

  // byte clock 200 MHz, word clock rises with it at half rate
  initial forever begin
    byte_clk = 1'b1; rd_clk = 1'b1; #2.5;
    byte_clk = 1'b0; #2.5;
    byte_clk = 1'b1; rd_clk = 1'b0; #2.5;
    byte_clk = 1'b0; #2.5;
  end
  initial begin #3; forever begin wr_clk = ~wr_clk; #(wr_half); end end

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic [1:0] c, input logic [1:0] f);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge wr_clk);
      in_valid = 1'b1; in_data = d; in_ctrl = c; in_fdisp = f;
      acc = in_ready;
      if (!acc) stalls++;
      @(posedge wr_clk);
    end
    expq.push_back({c[0], f[0], d[7:0]});
    expq.push_back({c[1], f[1], d[15:8]});
  endtask

  task automatic idle(input int n);
    @(negedge wr_clk);
    in_valid = 1'b0;
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge wr_clk); in_valid = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge byte_clk);
    expq.delete();
    seen_valid = 0;
    // R9: state under reset
    check(out_valid == 1'b0 && out_byte == 8'h00, "R9 output in reset", {out_valid, out_byte}, 32'h0);
    check(!tx_overflow && !tx_underflow, "R9 flags in reset", {tx_overflow, tx_underflow}, 32'h0);
    check(in_ready == 1'b1, "R9 ready in reset", in_ready, 1);
    @(negedge byte_clk); #1 rst_n = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge rd_clk);
    repeat (4) @(negedge rd_clk);
    check(expq.size() == 0, "R3 all words emitted", expq.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge byte_clk) begin
    if (rst_n && mon_en) begin
      if (out_valid) begin
        seen_valid++;
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected byte", out_byte, 0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check(out_byte == e[7:0], "R1 byte order", out_byte, e[7:0]);
          check({out_ctrl, out_fdisp} == e[9:8], "R2 lane flags", {out_ctrl, out_fdisp}, e[9:8]);
        end
      end else begin
        check(out_byte == 8'h00 && !out_ctrl && !out_fdisp, "R7 idle output zero",
              {out_ctrl, out_fdisp, out_byte}, 0);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got %h exp %h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    repeat (10) @(negedge rd_clk);
    check(seen_valid == 0, "R7 no output before first read", seen_valid, 0);
    check(!tx_underflow, "R6 no underflow before start", tx_underflow, 0);

    // continuous burst with varied patterns
    send(16'h146F, 2'b00, 2'b00);
    send(16'hC6F1, 2'b01, 2'b10);
    send(16'hAAB3, 2'b10, 2'b01);
    send(16'h0000, 2'b11, 2'b11);
    send(16'hFFFF, 2'b00, 2'b11);
    for (int i = 0; i < 15; i++)
      send(16'(i * 16'h1357 + 16'h0102), 2'(i), 2'(i >> 1));
    idle(1);
    drain();
    check(seen_valid == 40, "R3 byte count", seen_valid, 40);
    check(tx_underflow == 1'b1, "R6 underflow after stream ends", tx_underflow, 1);
    repeat (10) @(negedge rd_clk);
    check(tx_underflow == 1'b1, "R6 underflow sticky", tx_underflow, 1);
    check(!tx_overflow, "R5 no overflow at equal rate", tx_overflow, 0);

    // start threshold
    do_reset();
    send(16'h5A3C, 2'b10, 2'b00);
    idle(30);
    check(seen_valid == 0, "R8 single word held", seen_valid, 0);
    check(expq.size() == 2, "R8 word still queued", expq.size(), 2);
    send(16'h9E71, 2'b01, 2'b01);
    idle(1);
    drain();

    // gap mid-stream after start
    send(16'h1234, 2'b01, 2'b00);
    send(16'h5678, 2'b00, 2'b10);
    send(16'h9ABC, 2'b11, 2'b01);
    idle(1);
    drain();

    // overflow: write clock deliberately doubled
    do_reset();
    wr_half = 2.5;
    stalls = 0;
    for (int i = 0; i < 30; i++) send(16'hA500 + 16'(i), 2'(i), 2'(i + 1));
    idle(1);
    wr_half = 5.0;
    check(stalls > 0, "R4 ready falls when full", stalls, 1);
    check(tx_overflow == 1'b1, "R5 overflow flagged", tx_overflow, 1);
    drain();
    check(tx_overflow == 1'b1, "R5 overflow sticky", tx_overflow, 1);
    do_reset();
    repeat (4) @(negedge wr_clk);
    check(!tx_overflow && !tx_underflow, "R9 flags cleared", {tx_overflow, tx_underflow}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule